// File: doc/BRIEF.md
# Tolerant Pulse-Distance Frame Decoder

This block turns a stream of already-captured pulse symbols into decoded remote-control style frames. Each symbol carries two phases, each phase being a level bit and a 15-bit duration counted in timer ticks. The decoder sorts every accepted symbol into a start marker, a logic one or a logic zero by checking each phase duration against a fixed tolerance window around a nominal value. After a start marker it gathers 32 data symbols into a 16-bit address word and a 16-bit command word.

Upstream logic measures edges and packs them into symbols. This block only classifies and assembles. A completed frame is announced by a one-cycle pulse with both words. A data symbol that is neither a one nor a zero ends the frame with a one-cycle error pulse. Durations are compared in ticks at 8 ticks per 10 us. The nominal values are 7200/3600 ticks for the start marker, 448/1352 for a one and 448/448 for a zero. The margin is 128 ticks.

Top module: `pulse_frame_decoder`

## Requirements
- R1: While `rst_n` is low, `sym_ready`, `frame_valid`, `frame_err`, `frame_addr` and `frame_cmd` are all 0. `sym_ready` is 1 from the first clock edge after reset release onward.
- R2: `sym_word` is laid out as bit 31 = second-phase level, bits 30:16 = second-phase duration, bit 15 = first-phase level, bits 14:0 = first-phase duration. A symbol is classified at all only when the first-phase level is 1 and the second-phase level is 0.
- R3: A phase matches a nominal tick count N when its duration D satisfies N-128 < D < N+128, both bounds strict.
- R4: A start marker needs a first phase matching 7200 ticks and a second phase matching 3600 ticks.
- R5: A one needs 448/1352 ticks and a zero needs 448/448 ticks.
- R6: The first 16 data symbols fill `frame_addr` from bit 0 upward. The next 16 fill `frame_cmd` from bit 0 upward.
- R7: `frame_valid` is high for exactly the one cycle after the 32nd valid data symbol is accepted. `frame_addr` and `frame_cmd` change only in that cycle and otherwise hold their values.
- R8: A data symbol that is neither a one nor a zero raises `frame_err` for one cycle and discards the partial frame. That symbol is never taken as a new start marker.
- R9: The symbol after the 32nd data symbol is consumed without any check. Even if it is a valid start marker, it does not begin a frame.
- R10: While waiting for a start marker, any other symbol is dropped with no error and no output change.
- R11: A symbol presented with `sym_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Symbol word is valid |
| sym_ready | output | 1 | Decoder accepts a symbol this cycle |
| sym_word | input | 32 | Packed two-phase symbol (levels and durations) |
| frame_valid | output | 1 | One-cycle pulse: a frame was decoded |
| frame_addr | output | 16 | Decoded address word |
| frame_cmd | output | 16 | Decoded command word |
| frame_err | output | 1 | One-cycle pulse: a malformed data symbol aborted the frame |

## Verification
A wrong internal state shows up at the ports within one frame. A bit counter that is off by one shifts every decoded word, or produces `frame_valid` one symbol early or late. A state machine stuck waiting for a start marker produces no pulse at all where one is expected. A missed return to the search state after an error produces a spurious frame from the symbols that follow. Window bounds that are off by one tick show up in the directed cases at N±127 and N±128, on the first symbol that sits on the boundary.

// File: rtl/pdd_pkg.sv
// Shared types for the pulse-distance frame decoder.
// Assumes 15-bit tick durations, with each phase's level in the bit above its duration.
package pdd_pkg;
    localparam int DUR_W = 15;

    typedef struct packed {
        logic             lvl1;
        logic [DUR_W-1:0] dur1;
        logic             lvl0;
        logic [DUR_W-1:0] dur0;
    } symbol_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DATA = 2'd1,
        ST_SKIP = 2'd2
    } dec_state_e;
endpackage

// File: rtl/window_match.sv
// Strict tolerance window: hit when TARGET-MARGIN < dur < TARGET+MARGIN.
// Assumes TARGET >= MARGIN, so that the lower bound is not negative.
module window_match #(
    parameter int W      = 15,
    parameter int TARGET = 448,
    parameter int MARGIN = 128
) (
    input  logic [W-1:0] dur,
    output logic         hit
);
    localparam logic [W:0] LO = (W+1)'(TARGET - MARGIN);
    localparam logic [W:0] HI = (W+1)'(TARGET + MARGIN);

    // Compare in one extra bit so that HI cannot wrap.
    always_comb hit = ({1'b0, dur} > LO) && ({1'b0, dur} < HI);
endmodule

// File: rtl/sym_classifier.sv
// Sorts one symbol into start marker, one or zero. Purely combinational.
// Assumes the nominal microsecond values convert to whole tick counts.
module sym_classifier
    import pdd_pkg::*;
#(
    parameter int TICKS_PER_10US = 8,
    parameter int MARGIN_US      = 160,
    parameter int HDR_ON_US      = 9000,
    parameter int HDR_OFF_US     = 4500,
    parameter int MARK_US        = 560,
    parameter int ONE_OFF_US     = 1690,
    parameter int ZERO_OFF_US    = 560
) (
    input  symbol_t sym,
    output logic    is_hdr,
    output logic    is_one,
    output logic    is_zero
);
    localparam int MARGIN_T = MARGIN_US * TICKS_PER_10US / 10;
    localparam int NWIN     = 5;
    localparam int TGT_T [NWIN] = '{
        HDR_ON_US   * TICKS_PER_10US / 10,
        HDR_OFF_US  * TICKS_PER_10US / 10,
        MARK_US     * TICKS_PER_10US / 10,
        ONE_OFF_US  * TICKS_PER_10US / 10,
        ZERO_OFF_US * TICKS_PER_10US / 10
    };

    logic [NWIN-1:0] hit;
    logic            shape_ok;

    // One window per nominal value. Window 0 and window 2 look at the first phase.
    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam bit FIRST = (i == 0) || (i == 2);
        window_match #(.W(DUR_W), .TARGET(TGT_T[i]), .MARGIN(MARGIN_T)) u_win (
            .dur (FIRST ? sym.dur0 : sym.dur1),
            .hit (hit[i])
        );
    end

    // Level pattern must be active then inactive; durations pick the class.
    always_comb begin
        shape_ok = sym.lvl0 && !sym.lvl1;
        is_hdr   = shape_ok && hit[0] && hit[1];
        is_one   = shape_ok && hit[2] && hit[3];
        is_zero  = shape_ok && hit[2] && hit[4];
    end
endmodule

// File: rtl/frame_assembler.sv
// Frame state machine: waits for a start marker, shifts in NBITS data
// symbols LSB first, reports the words, then drops one trailing symbol.
// Assumes at most one class flag is high per symbol.
module frame_assembler
    import pdd_pkg::*;
#(
    parameter int NBITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               is_hdr,
    input  logic               is_one,
    input  logic               is_zero,
    output logic               frame_valid,
    output logic               frame_err,
    output logic [NBITS/2-1:0] frame_addr,
    output logic [NBITS/2-1:0] frame_cmd
);
    localparam int                 CNT_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(NBITS - 1);

    dec_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [NBITS-1:0]  sh;
    logic [NBITS-1:0]  sh_next;

    // Next shift value: the new bit enters at the top, so the first bit ends at bit 0.
    always_comb sh_next = {is_one, sh[NBITS-1:1]};

    // State, counter, shift register and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_HUNT;
            cnt         <= '0;
            sh          <= '0;
            frame_valid <= 1'b0;
            frame_err   <= 1'b0;
            frame_addr  <= '0;
            frame_cmd   <= '0;
        end else begin
            frame_valid <= 1'b0;
            frame_err   <= 1'b0;
            if (take) begin
                case (state)
                    ST_HUNT: if (is_hdr) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end
                    ST_DATA: if (is_one || is_zero) begin
                        sh  <= sh_next;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            state       <= ST_SKIP;
                            frame_valid <= 1'b1;
                            {frame_cmd, frame_addr} <= sh_next;
                        end
                    end else begin
                        frame_err <= 1'b1;
                        state     <= ST_HUNT;
                    end
                    ST_SKIP: state <= ST_HUNT;
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // R4
    class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_hdr, is_one, is_zero}));
    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    // R7
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((frame_addr != $past(frame_addr)) || (frame_cmd != $past(frame_cmd))) |-> frame_valid);
    // R8
    err_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (state == ST_HUNT) && !frame_valid);
    // R9
    skip_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> (state == ST_SKIP) || (state == ST_HUNT));
endmodule

// File: rtl/pulse_frame_decoder.sv
// Top: accepts packed two-phase symbols, classifies them and assembles
// address/command frames. Always ready once out of reset.
// Assumes upstream gives durations in ticks at the configured tick rate.
module pulse_frame_decoder
    import pdd_pkg::*;
#(
    parameter int TICKS_PER_10US = 8,
    parameter int MARGIN_US      = 160,
    parameter int NBITS          = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sym_valid,
    output logic                  sym_ready,
    input  logic [2*DUR_W+1:0]    sym_word,
    output logic                  frame_valid,
    output logic [NBITS/2-1:0]    frame_addr,
    output logic [NBITS/2-1:0]    frame_cmd,
    output logic                  frame_err
);
    symbol_t sym;
    logic    take, is_hdr, is_one, is_zero;

    // Ready rises on the first edge out of reset and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) sym_ready <= 1'b0;
        else        sym_ready <= 1'b1;
    end

    // Handshake and field unpacking.
    always_comb begin
        take = sym_valid && sym_ready;
        sym  = symbol_t'(sym_word);
    end

    sym_classifier #(
        .TICKS_PER_10US (TICKS_PER_10US),
        .MARGIN_US      (MARGIN_US)
    ) u_cls (
        .sym     (sym),
        .is_hdr  (is_hdr),
        .is_one  (is_one),
        .is_zero (is_zero)
    );

    frame_assembler #(.NBITS(NBITS)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .is_hdr      (is_hdr),
        .is_one      (is_one),
        .is_zero     (is_zero),
        .frame_valid (frame_valid),
        .frame_err   (frame_err),
        .frame_addr  (frame_addr),
        .frame_cmd   (frame_cmd)
    );

    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sym_ready);
    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && frame_err));
endmodule

// File: tb/pulse_frame_decoder_bench.sv
module pulse_frame_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic        sym_ready;
    logic [31:0] sym_word = '0;
    logic        frame_valid, frame_err;
    logic [15:0] frame_addr, frame_cmd;

    int checks = 0;
    int errors = 0;
    bit got_frame, got_err;
    logic [15:0] cap_addr, cap_cmd;

    always #2 clk = ~clk;

    pulse_frame_decoder u_pulse_frame_decoder (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_word(sym_word), .frame_valid(frame_valid), .frame_addr(frame_addr),
        .frame_cmd(frame_cmd), .frame_err(frame_err)
    );

    // Tick counts derived from microseconds at 8 ticks per 10 us.
    function automatic int tk(input int us);
        return us * 8 / 10;
    endfunction

    function automatic logic [31:0] pack(input bit l0, input int d0, input bit l1, input int d1);
        return {l1, 15'(d1), l0, 15'(d0)};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        got_frame = 0;
        got_err   = 0;
    endtask

    // Present one symbol for one accepting edge; record output pulses.
    task automatic send(input logic [31:0] w);
        sym_word  = w;
        sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        if (frame_valid) begin
            got_frame = 1;
            cap_addr  = frame_addr;
            cap_cmd   = frame_cmd;
        end
        if (frame_err) got_err = 1;
    endtask

    function automatic int jit(input bit en);
        return en ? int'($urandom_range(0, 254)) - 127 : 0;
    endfunction

    task automatic send_hdr(input bit j);
        send(pack(1, tk(9000) + jit(j), 0, tk(4500) + jit(j)));
    endtask

    task automatic send_bits(input logic [31:0] v, input bit j);
        for (int i = 0; i < 32; i++)
            send(pack(1, tk(560) + jit(j), 0, (v[i] ? tk(1690) : tk(560)) + jit(j)));
    endtask

    task automatic send_stop();
        send(pack(1, tk(560), 0, 15'h7fff));
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] ra, rc;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sym_ready == 0 && frame_valid == 0 && frame_err == 0 && frame_addr == 0 && frame_cmd == 0,
            "R1 reset", {sym_ready, frame_valid, frame_err, frame_addr, frame_cmd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sym_ready == 1, "R1 ready", sym_ready, 1);

        // R4 R5 R6 R7 nominal frame
        clear_flags();
        send_hdr(0); send_bits({16'h5a3c, 16'hee11}, 0);
        chk(got_frame && cap_addr == 16'hee11, "R6 addr", cap_addr, 16'hee11);
        chk(cap_cmd == 16'h5a3c, "R6 cmd", cap_cmd, 16'h5a3c);
        @(negedge clk);
        chk(frame_valid == 0, "R7 single pulse", frame_valid, 0);
        send_stop();

        // R11 valid low: header-like word with valid low, then bits; no frame
        clear_flags();
        sym_word = pack(1, tk(9000), 0, tk(4500));
        repeat (4) @(negedge clk);
        send_bits(32'h0000ffff, 0);
        chk(!got_frame && !got_err && frame_addr == 16'hee11, "R11 valid low", frame_addr, 16'hee11);

        // R3 upper bound inside (+127)
        clear_flags();
        send(pack(1, tk(9000) + 127, 0, tk(4500) + 127)); send_bits(32'h00010002, 0); send_stop();
        chk(got_frame && cap_addr == 16'h0002, "R3 +127 accepted", cap_addr, 16'h0002);
        // R3 lower bound inside (-127)
        clear_flags();
        send(pack(1, tk(9000) - 127, 0, tk(4500) - 127)); send_bits(32'h00030004, 0); send_stop();
        chk(got_frame && cap_cmd == 16'h0003, "R3 -127 accepted", cap_cmd, 16'h0003);
        // R3 R10 +128 rejected, silently
        clear_flags();
        send(pack(1, tk(9000) + 128, 0, tk(4500))); send_bits(32'h12345678, 0);
        chk(!got_frame && !got_err, "R3 R10 +128 rejected", got_frame, 0);
        // R3 -128 on second phase rejected
        clear_flags();
        send(pack(1, tk(9000), 0, tk(4500) - 128)); send_bits(32'h12345678, 0);
        chk(!got_frame && !got_err, "R3 -128 rejected", got_frame, 0);
        chk(frame_addr == 16'h0004, "R7 hold", frame_addr, 16'h0004);

        // R5 data bit windows at edges: one low at 1352+127, zero low at 448-127
        clear_flags();
        send_hdr(0);
        send(pack(1, tk(560), 0, tk(1690) + 127));
        send(pack(1, tk(560), 0, tk(560) - 127));
        send_bits(32'h3fff_fffd, 0);
        chk(got_frame && cap_addr == 16'hfff5, "R5 edge bits", cap_addr, 16'hfff5);
        // (30 bits from send_bits' first 30 fill; bit31 from word 32 wait) -- stop below
        send_stop();

        // R2 inverted level on header: ignored
        clear_flags();
        send(pack(0, tk(9000), 1, tk(4500))); send_bits(32'h0, 0);
        chk(!got_frame && !got_err, "R2 level header", got_frame, 0);
        // R2 R8 second-phase level high on data bit -> error
        clear_flags();
        send_hdr(0); send(pack(1, tk(560), 1, tk(560)));
        chk(got_err && !got_frame, "R2 R8 bad level err", got_err, 1);
        // R8 bad symbol that is a header: not reused
        clear_flags();
        send_hdr(0); send(pack(1, tk(560), 0, tk(560))); send_hdr(0);
        chk(got_err, "R8 err pulse", got_err, 1);
        clear_flags();
        send_bits(32'hdeadbeef, 0);
        chk(!got_frame && !got_err, "R8 header not reused", got_frame, 0);

        // R9 stop that looks like a header is consumed
        clear_flags();
        send_hdr(0); send_bits(32'h11112222, 0); send_hdr(0);
        chk(got_frame && cap_addr == 16'h2222, "R9 frame", cap_addr, 16'h2222);
        clear_flags();
        send_bits(32'h99998888, 0);
        chk(!got_frame && !got_err, "R9 stop unchecked", got_frame, 0);

        // R3 R6 random frames with jitter
        for (int n = 0; n < 24; n++) begin
            ra = 16'($urandom); rc = 16'($urandom);
            clear_flags();
            send_hdr(1); send_bits({rc, ra}, 1);
            if ($urandom_range(0, 1)) send_stop(); else send_hdr(1);
            chk(got_frame && cap_addr == ra, "R6 random addr", cap_addr, ra);
            chk(cap_cmd == rc && !got_err, "R6 random cmd", cap_cmd, rc);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule